// File: doc/BRIEF.md
# Timed State Machine with Saturating Cycle Timer

This block is a two-state controller in which one state is timed and the other is not. A single shared cycle timer measures how long the machine has stayed in its present state. The timer climbs by one on every clock while the state is unchanged. It stops at a fixed limit and holds there. It returns to zero only on the clock edge at which the state changes.

Change detection is combinational: the control compares the present state code with the next state code, and any difference raises a clear strobe for the timer. Because the timer holds at its limit instead of wrapping, the timed state may wait on the condition input for any length of time after the limit has passed and still see the timeout. In the untimed state the timer needs no special handling; it fills up and then stops toggling.

When the limit is a power of two, the timeout compare reduces to the timer's top bit. The timer width is derived from the limit, so a one-second wait at 100 MHz gives a 27-bit timer.

Top module: `timedFsm`

## Requirements
- R1: A synchronous reset, active high, puts the machine in the timed state and the timer at zero, so timeout is low during reset and in the cycle after it.
- R2: While the state does not change and the timer is below `TMAX`, the timer rises by exactly one each clock.
- R3: The timer never exceeds `TMAX`; once there it holds while the state is unchanged, so timeout stays high.
- R4: `timeout` is high exactly when the timer value is at least `TMAX`, and is combinational from the timer.
- R5: In the timed state the machine moves to the untimed state only when `timeout` is high and `x` is 2'b00 or 2'b11; with `timeout` low it stays whatever `x` is.
- R6: In the timed state with `timeout` high and `x` equal to 2'b01 or 2'b10, the machine stays and the timer stays saturated rather than restarting.
- R7: In the untimed state the machine returns to the timed state when `x` is 2'b11 and stays for any other `x`, whatever the timeout.
- R8: On every state change the timer is cleared on that same edge, so it reads zero in the first cycle in the new state.
- R9: The state output uses sequential coding: 0 means the timed state and 1 means the untimed state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 2 | Condition input that steers the transitions |
| state | output | 1 | Present state code (0 timed, 1 untimed) |
| timeout | output | 1 | High while the timer is at or above its limit |

## Verification
The assertions assume that `x` and `rst` are settled well away from the rising edge. They also assume that reset is held for at least two clocks before the first checked cycle, so that the past-value terms see reset values and not the unknowns present at power-up. The bench changes `x` and `rst` only on the falling edge and opens with a three-cycle reset. Its stimulus keeps each `x` value long enough to reach saturation in both states, then adds back-to-back transitions and a reset in the middle of the run.

// File: rtl/timedFsmPkg.sv
package timedFsmPkg;
  // Sequential coding keeps the present/next comparator narrow.
  typedef enum logic {
    ST_TIMED   = 1'b0,
    ST_UNTIMED = 1'b1
  } fsmState_e;

  // Strobes from control to timer datapath.
  typedef struct packed {
    logic timerClear;
  } ctrlStrobe_t;
endpackage

// File: rtl/timedFsmTimer.sv
module timedFsmTimer
  import timedFsmPkg::*;
#(
  parameter int TMAX  = 8,
  parameter int CNT_W = $clog2(TMAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic             timeout
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(TMAX);
  localparam bit POW2 = ((TMAX & (TMAX - 1)) == 0);

  always_ff @(posedge clk) begin
    if (rst || strobe.timerClear) begin
      count <= '0;
    end else if (count != SAT) begin
      count <= count + 1'b1;
    end
  end

  generate
    if (POW2) begin : gMsbTest
      // count never exceeds SAT, and SAT is the only value with the top bit set
      assign timeout = count[CNT_W-1];
    end else begin : gCompare
      assign timeout = (count >= SAT);
    end
  endgenerate
endmodule

// File: rtl/timedFsmCtrl.sv
module timedFsmCtrl
  import timedFsmPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  x,
  input  logic        timeout,
  output fsmState_e   presState,
  output ctrlStrobe_t strobe
);
  fsmState_e nextState;

  always_comb begin
    nextState = presState;
    case (presState)
      ST_TIMED: begin
        if (timeout && (x == 2'b00 || x == 2'b11)) nextState = ST_UNTIMED;
      end
      ST_UNTIMED: begin
        if (x == 2'b11) nextState = ST_TIMED;
      end
      default: nextState = ST_TIMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) presState <= ST_TIMED;
    else     presState <= nextState;
  end

  always_comb begin
    strobe.timerClear = (presState != nextState);
  end
endmodule

// File: rtl/timedFsm.sv
module timedFsm
  import timedFsmPkg::*;
#(
  parameter int TMAX = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] x,
  output logic       state,
  output logic       timeout
);
  localparam int CNT_W = $clog2(TMAX + 1);

  ctrlStrobe_t      strobe;
  fsmState_e        presState;
  logic [CNT_W-1:0] count;

  timedFsmCtrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .x         (x),
    .timeout   (timeout),
    .presState (presState),
    .strobe    (strobe)
  );

  timedFsmTimer #(.TMAX(TMAX), .CNT_W(CNT_W)) uTimer (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .count   (count),
    .timeout (timeout)
  );

  assign state = logic'(presState);
endmodule

// File: rtl/timedFsmChk.sv
module timedFsmChk #(
  parameter int TMAX  = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       x,
  input logic             state,
  input logic             timeout,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(TMAX);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (count == '0 && state == 1'b0)) else $error("reset"); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(state) && $past(count) != SAT) |-> count == $past(count) + 1'b1) else $error("step"); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= SAT) else $error("overflow"); // R3
  AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (rst) timeout == (count >= SAT)) else $error("flag"); // R4
  AST_TIMED_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == 1'b0 && !timeout) |=> state == 1'b0) else $error("early leave"); // R5
  AST_TIMED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == 1'b0 && timeout && (x == 2'b01 || x == 2'b10)) |=> (state == 1'b0 && timeout)) else $error("hold"); // R6
  AST_UNTIMED_STAY: assert property (@(posedge clk) disable iff (rst)
    (state == 1'b1 && x != 2'b11) |=> state == 1'b1) else $error("untimed"); // R7
  AST_CLEAR_ON_MOVE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(state)) |-> count == '0) else $error("clear"); // R8
endmodule

bind timedFsm timedFsmChk #(.TMAX(TMAX), .CNT_W(CNT_W)) uChk (
  .clk     (clk),
  .rst     (rst),
  .x       (x),
  .state   (state),
  .timeout (timeout),
  .count   (count)
);

// File: tb/sim_timedFsm.sv
module sim_timedFsm;
  localparam int TMAX = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] x = 2'b00;
  logic       state;
  logic       timeout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // scoreboard queues: expected {state, timeout} and the requirement tag
  logic [1:0] expQ[$];
  string      tagQ[$];

  // reference model
  logic mState = 1'b0;
  int   mCnt   = 0;

  timedFsm #(.TMAX(TMAX)) u0 (
    .clk(clk), .rst(rst), .x(x), .state(state), .timeout(timeout)
  );

  always #10 clk = ~clk;

  task automatic resetCycle();
    @(negedge clk);
    rst = 1'b1;
    mState = 1'b0;
    mCnt = 0;
    expQ.push_back({1'b0, 1'b0});
    tagQ.push_back("R1");
  endtask

  task automatic drive(input logic [1:0] val, input int n);
    for (int i = 0; i < n; i++) begin
      logic  tmo;
      logic  nxt;
      string tag;
      @(negedge clk);
      rst = 1'b0;
      x = val;
      tmo = (mCnt >= TMAX);
      if (mState == 1'b0) nxt = (tmo && (val == 2'b00 || val == 2'b11)) ? 1'b1 : 1'b0;
      else                nxt = (val == 2'b11) ? 1'b0 : 1'b1;
      if (nxt != mState)                                  tag = (mState == 1'b0) ? "R5 R8" : "R7 R8";
      else if (mState == 1'b0 && !tmo)                    tag = "R2 R5";
      else if (mState == 1'b0 && (val == 2'b01 || val == 2'b10)) tag = "R6 R3";
      else if (mState == 1'b1)                            tag = tmo ? "R7 R3" : "R7 R2";
      else                                                tag = "R3";
      if (nxt != mState)  mCnt = 0;
      else if (mCnt < TMAX) mCnt = mCnt + 1;
      mState = nxt;
      expQ.push_back({mState, logic'(mCnt >= TMAX)});
      tagQ.push_back(tag);
    end
  endtask

  // monitor: compares away from the rising edge
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      logic [1:0] e;
      string      t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({state, timeout} !== e) begin
        errors++;
        $display("FAIL %s R4 R9: state/timeout got %b%b expected %b%b", t, state, timeout, e[1], e[0]);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    resetCycle();
    resetCycle();
    resetCycle();
    drive(2'b01, 12);  // timed state saturates and waits
    drive(2'b10, 5);
    drive(2'b00, 1);   // leave to untimed
    drive(2'b01, 12);  // untimed saturates
    drive(2'b11, 1);   // back to timed
    drive(2'b00, 4);   // timer not expired, must stay
    drive(2'b11, 14);  // expire, then bounce between states
    drive(2'b10, 3);
    resetCycle();      // mid-run reset
    resetCycle();
    drive(2'b11, 10);
    drive(2'b00, 9);
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule